// File: doc/BRIEF.md
# Forced Refresh Holdoff Controller

This block schedules forced refreshes for a dynamic memory that sits behind a shared backing-store port. A local interval timer raises a refresh request at a fixed cadence. The request is acknowledged only when the arbiter reports that no backing-store cycle is in progress. Once acknowledged, the block raises a holdoff that the arbiter ORs into its own busy condition, so no new cycle can start while the memory is being refreshed.

During the holdoff the block drives a refresh strobe toward the array for a fixed number of clocks. It then produces a registered completion pulse on the local clock, and that pulse releases the holdoff. A request that finds the port busy stays pending and is acknowledged on the first idle clock. The timer keeps its own cadence whatever the grant latency is. If a further interval expires while a request is still unacknowledged, a sticky overrun flag is raised.

Top module: `refresh_holdoff_ctrl`

## Requirements
- R1: While reset is asserted and on the first clock after its release, want_refresh_o, holdoff_o, refresh_strobe_o, refresh_done_o and overrun_o are all low.
- R2: want_refresh_o is set on the INTERVAL_CYCLES-th rising clock edge after reset release and again every INTERVAL_CYCLES edges after that, whether or not earlier requests were granted promptly.
- R3: holdoff_o rises only on an edge where want_refresh_o is high, port_busy_i is sampled low and holdoff_o is low. A pending request is granted on the first such edge.
- R4: Once set, holdoff_o stays high until the edge that follows the refresh_done_o pulse, and it falls on that edge.
- R5: refresh_strobe_o is high for exactly the first REFRESH_CYCLES clocks of each holdoff, and never outside a holdoff.
- R6: refresh_done_o is a single-cycle pulse in the clock right after the last strobe clock, while holdoff_o is still high.
- R7: want_refresh_o clears on the grant edge, unless a new interval expires on that same edge, in which case it stays set.
- R8: overrun_o is set on an interval expiry that finds want_refresh_o high and not granted on that edge. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_busy_i | input | 1 | Arbiter reports a backing-store cycle in progress |
| want_refresh_o | output | 1 | Refresh requested and not yet acknowledged |
| holdoff_o | output | 1 | Refresh acknowledged; ORed into the arbiter's busy |
| refresh_strobe_o | output | 1 | Refresh strobe toward the memory array |
| refresh_done_o | output | 1 | Registered one-clock refresh-complete pulse |
| overrun_o | output | 1 | Sticky: an interval expired with a request still pending |

## Verification
A request becomes visible one edge after the timer reaches its last count. A grant shows as holdoff_o and the strobe in the clock after the edge that sampled an idle port. The completion pulse follows REFRESH_CYCLES clocks later, and the release one clock after that. The bench drives port_busy_i at the falling edge and advances a behavioural model at each rising edge. It compares every output at the next falling edge, so each result is checked in exactly the clock it is due. Busy patterns cover an idle port, random traffic, a busy stretch longer than two intervals, and a mid-run reset.

// File: rtl/refresh_holdoff_pkg.sv
package refresh_holdoff_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } hold_phase_e;

    typedef struct packed {
        logic want;
        logic overrun;
    } req_state_t;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int INTERVAL_CYCLES = 139
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic expire_o
);
    localparam int CW = (INTERVAL_CYCLES > 1) ? $clog2(INTERVAL_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] count;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.count == LAST) begin
            st_d.count = '0;
        end else begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire_o = (st_q.count == LAST);

endmodule

// File: rtl/refresh_request_tracker.sv
module refresh_request_tracker
    import refresh_holdoff_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic expire_i,
    input  logic grant_i,
    output logic want_o,
    output logic overrun_o
);
    req_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (expire_i) begin
            st_d.want = 1'b1;
        end else if (grant_i) begin
            st_d.want = 1'b0;
        end
        if (expire_i && st_q.want && !grant_i) begin
            st_d.overrun = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign want_o    = st_q.want;
    assign overrun_o = st_q.overrun;

endmodule

// File: rtl/refresh_holdoff_fsm.sv
module refresh_holdoff_fsm
    import refresh_holdoff_pkg::*;
#(
    parameter int REFRESH_CYCLES = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic want_i,
    input  logic busy_i,
    output logic grant_o,
    output logic holdoff_o,
    output logic strobe_o,
    output logic done_o
);
    localparam int SW = (REFRESH_CYCLES > 1) ? $clog2(REFRESH_CYCLES) : 1;
    localparam logic [SW-1:0] SEQ_LAST = SW'(REFRESH_CYCLES - 1);

    typedef struct packed {
        hold_phase_e   phase;
        logic [SW-1:0] seq;
    } hof_state_t;

    hof_state_t st_d, st_q;
    logic       grant;

    always_comb begin
        st_d  = st_q;
        grant = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (want_i && !busy_i) begin
                    grant       = 1'b1;
                    st_d.phase  = PH_RUN;
                    st_d.seq    = '0;
                end
            end
            PH_RUN: begin
                if (st_q.seq == SEQ_LAST) begin
                    st_d.phase = PH_DONE;
                end else begin
                    st_d.seq = st_q.seq + 1'b1;
                end
            end
            PH_DONE: begin
                st_d.phase = PH_IDLE;
                st_d.seq   = '0;
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.seq   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, seq: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o   = grant;
    assign holdoff_o = (st_q.phase != PH_IDLE);
    assign strobe_o  = (st_q.phase == PH_RUN);
    assign done_o    = (st_q.phase == PH_DONE);

endmodule

// File: rtl/refresh_holdoff_ctrl.sv
module refresh_holdoff_ctrl #(
    parameter int INTERVAL_CYCLES = 139,
    parameter int REFRESH_CYCLES  = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic port_busy_i,
    output logic want_refresh_o,
    output logic holdoff_o,
    output logic refresh_strobe_o,
    output logic refresh_done_o,
    output logic overrun_o
);
    logic expire;
    logic grant;
    logic want;

    refresh_interval_timer #(
        .INTERVAL_CYCLES(INTERVAL_CYCLES)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .expire_o(expire)
    );

    refresh_request_tracker u_req (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .expire_i (expire),
        .grant_i  (grant),
        .want_o   (want),
        .overrun_o(overrun_o)
    );

    refresh_holdoff_fsm #(
        .REFRESH_CYCLES(REFRESH_CYCLES)
    ) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .want_i   (want),
        .busy_i   (port_busy_i),
        .grant_o  (grant),
        .holdoff_o(holdoff_o),
        .strobe_o (refresh_strobe_o),
        .done_o   (refresh_done_o)
    );

    assign want_refresh_o = want;

endmodule

// File: rtl/refresh_holdoff_ctrl_chk.sv
module refresh_holdoff_ctrl_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic port_busy_i,
    input logic want_refresh_o,
    input logic holdoff_o,
    input logic refresh_strobe_o,
    input logic refresh_done_o,
    input logic overrun_o
);
    // R3
    grant_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(holdoff_o) |-> !$past(port_busy_i) && $past(want_refresh_o));

    // R4
    holdoff_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (holdoff_o && !refresh_done_o) |=> holdoff_o);

    // R4
    release_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_done_o |=> !holdoff_o);

    // R5
    strobe_in_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_strobe_o |-> holdoff_o);

    // R5
    strobe_at_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(holdoff_o) |-> refresh_strobe_o);

    // R6
    done_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_done_o |=> !refresh_done_o);

    // R6
    done_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_done_o |-> holdoff_o && !refresh_strobe_o && $past(refresh_strobe_o));

    // R8
    overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_o |=> overrun_o);

    // R8
    overrun_needs_want_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(overrun_o) |-> $past(want_refresh_o));

endmodule

bind refresh_holdoff_ctrl refresh_holdoff_ctrl_chk u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .port_busy_i     (port_busy_i),
    .want_refresh_o  (want_refresh_o),
    .holdoff_o       (holdoff_o),
    .refresh_strobe_o(refresh_strobe_o),
    .refresh_done_o  (refresh_done_o),
    .overrun_o       (overrun_o)
);

// File: tb/refresh_holdoff_ctrl_bench.sv
`timescale 1ns/1ps
module refresh_holdoff_ctrl_bench;
    localparam int INTERVAL = 139;
    localparam int REFRESH  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b0;
    logic want, hold, strobe, done, ovr;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    refresh_holdoff_ctrl #(
        .INTERVAL_CYCLES(INTERVAL),
        .REFRESH_CYCLES (REFRESH)
    ) u_refresh_holdoff_ctrl (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .port_busy_i     (busy),
        .want_refresh_o  (want),
        .holdoff_o       (hold),
        .refresh_strobe_o(strobe),
        .refresh_done_o  (done),
        .overrun_o       (ovr)
    );

    // behavioural model
    int m_tick = 0;       // edges since reset release, modulo interval
    bit m_want = 0;
    int m_left = 0;       // holdoff clocks remaining (0 = no holdoff)
    bit m_ovr  = 0;

    always @(posedge clk) begin
        bit expire, grant;
        if (!rst_n) begin
            m_tick = 0; m_want = 0; m_left = 0; m_ovr = 0;
        end else begin
            m_tick = m_tick + 1;
            expire = (m_tick == INTERVAL);
            if (expire) m_tick = 0;
            grant = m_want && !busy && (m_left == 0);
            if (expire && m_want && !grant) m_ovr = 1;
            if (expire) m_want = 1;
            else if (grant) m_want = 0;
            if (m_left > 0) m_left = m_left - 1;
            else if (grant) m_left = REFRESH + 1;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        // R2 R7: request
        check("R2 R7 want_refresh", want, m_want);
        // R3 R4: holdoff
        check("R3 R4 holdoff", hold, m_left > 0);
        // R5: strobe during first REFRESH clocks of holdoff
        check("R5 strobe", strobe, m_left > 1);
        // R6: done pulse in last holdoff clock
        check("R6 done", done, m_left == 1);
        // R8: sticky overrun
        check("R8 overrun", ovr, m_ovr);
    endtask

    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            case (mode)
                0: busy = 1'b0;
                1: busy = 1'b1;
                default: busy = ($urandom_range(0, 99) < mode);
            endcase
        end
    endtask

    initial begin
        rst_n = 1'b0;
        busy  = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 want", want, 1'b0);
        check("R1 holdoff", hold, 1'b0);
        check("R1 strobe", strobe, 1'b0);
        check("R1 done", done, 1'b0);
        check("R1 overrun", ovr, 1'b0);
        rst_n = 1'b1;
        run(600, 0);                 // idle port: prompt grants
        run(1500, 60);               // random traffic: delayed grants
        run(1200, 90);               // heavy traffic
        run(INTERVAL * 2 + 20, 1);   // long busy: overrun
        run(300, 0);
        @(negedge clk);
        rst_n = 1'b0;                // mid-run reset
        @(negedge clk);
        check("R1 overrun cleared", ovr, 1'b0);
        check("R1 holdoff cleared", hold, 1'b0);
        rst_n = 1'b1;
        run(INTERVAL - 3, 0);
        run(40, 1);                  // request arrives while busy: stays pending
        run(400, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule